// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells the scheduler of an out-of-order core whether a load or a store should wait for an earlier store that is still in flight. It learns which memory instructions depend on each other from ordering violations. A violation reported by the pipeline puts the offending store and the load into one shared store set. From then on, every store of that set that enters the window records its sequence number as the set's newest in-flight store. Any later member of the set that is looked up is told to wait for that store.

Two tables do the work. The set-ID table is indexed by instruction address bits and holds a set ID and a valid flag. The last-store table is indexed by set ID and holds a valid flag, a sequence number and a thread tag. A lookup is combinational. Every update (dispatch of a store, issue of a store, violation training, squash, clear) takes effect at the clock edge. Sequence number 0 means "no dependence", so the pipeline never hands out sequence 0.

Top module: `ssp_predictor`

## Requirements
- R1: The set-ID table index of an address `pc` is `pc[OFFSET_BITS +: IDX_W]` (defaults: bits 7:2, 64 entries). Dispatch, issue, lookup and training all use this same index.
- R2: A fresh set ID is the low `SET_W` bits of `pc ^ (pc >> 10)`, computed from the store address of a violation (default 16 sets).
- R3: A lookup returns `look_seq_o = 0` and `look_dep_o = 0` when the set-ID entry of the address is invalid or the last-store entry of its set is invalid. Otherwise it returns the stored sequence number with `look_dep_o = 1`.
- R4: A dispatched store whose set-ID entry is valid writes its sequence number and thread tag into its set's last-store entry and marks it valid. A dispatched store whose set-ID entry is invalid changes nothing.
- R5: A dispatched load changes no state.
- R6: Violation training writes one ID, valid, into both the store's and the load's set-ID entries. If neither entry is valid, the ID is the hash of the store address. If exactly one is valid, the ID is that entry's ID. If both are valid, the ID is the smaller of the two.
- R7: An issued store invalidates its set's last-store entry only if that entry still holds the store's own sequence number.
- R8: Squash (sequence S, thread T) invalidates every valid last-store entry that has thread tag T and a sequence number greater than S (unsigned). Entries of other threads, and entries with a sequence number of S or less, are kept.
- R9: Clear invalidates every entry of both tables in one cycle.
- R10: After reset every entry of both tables is invalid.
- R11: Clear wins over every other update in the same cycle. A squash in the same cycle as a store insert also applies to the newly inserted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Invalidate both tables |
| disp_vld_i | input | 1 | Dispatch of a memory instruction |
| disp_store_i | input | 1 | 1 = dispatched instruction is a store, 0 = load |
| disp_pc_i | input | PC_W | Dispatched instruction address |
| disp_seq_i | input | SEQ_W | Dispatched sequence number |
| disp_tid_i | input | TID_W | Dispatched thread tag |
| look_pc_i | input | PC_W | Address to look up |
| look_dep_o | output | 1 | Lookup found an in-flight producer store |
| look_seq_o | output | SEQ_W | Producer store sequence number, 0 if none |
| issue_vld_i | input | 1 | Issue of a memory instruction |
| issue_store_i | input | 1 | 1 = issued instruction is a store |
| issue_pc_i | input | PC_W | Issued instruction address |
| issue_seq_i | input | SEQ_W | Issued sequence number |
| viol_vld_i | input | 1 | Ordering violation report |
| viol_store_pc_i | input | PC_W | Address of the older store |
| viol_load_pc_i | input | PC_W | Address of the younger load |
| sqsh_vld_i | input | 1 | Squash request |
| sqsh_seq_i | input | SEQ_W | Squash boundary sequence number |
| sqsh_tid_i | input | TID_W | Squash thread tag |

## Verification
The bench covers all three training cases.
- Fresh hash: the store address is chosen with bit 10 set, so a hash that drops the XOR term puts the store into a different set.
- Copy: one entry is valid and the other copies its ID. A design that copied in the wrong direction would break an existing set.
- Merge: both entries are valid, so a design that picked the larger ID would leave the load pointing at the wrong set.

Issue is tested with a stale sequence number, which must leave a newer store's entry in place. Squash is tested at the exact boundary sequence, with the wrong thread tag, and in the same cycle as an insert that it must cancel. Clear is tested in the same cycle as a store insert. After the clear, a store must not find a stale set ID and write a new entry.

// File: rtl/ssp_pkg.sv
// Package: shared types of the store set predictor.
// Assumes: nothing beyond the standard language.
package ssp_pkg;

    // Which rule decides the ID written by violation training.
    typedef enum logic [1:0] {
        TR_FRESH    = 2'd0,   // neither entry valid: hash the store address
        TR_USE_ST   = 2'd1,   // only the store entry is valid
        TR_USE_LD   = 2'd2,   // only the load entry is valid
        TR_MERGE    = 2'd3    // both valid: keep the smaller ID
    } train_case_e;

endpackage

// File: rtl/ssp_idt.sv
// Module: set-ID table. It maps an address index to a set ID with a valid flag.
// It has NRD combinational read ports and one training write that updates two
// entries with the same ID.
// Assumes: the two write indices may be equal. Clear has priority over a write.
module ssp_idt #(
    parameter int IDX_W = 6,
    parameter int SET_W = 4,
    parameter int NRD   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic [NRD-1:0][IDX_W-1:0]     rd_idx_i,
    output logic [NRD-1:0]                rd_vld_o,
    output logic [NRD-1:0][SET_W-1:0]     rd_id_o,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_a_i,
    input  logic [IDX_W-1:0]              wr_idx_b_i,
    input  logic [SET_W-1:0]              wr_id_i
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [SET_W-1:0] id_q [DEPTH];

    // Read ports: combinational lookup of flag and ID.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_vld_o[r] = vld_q[rd_idx_i[r]];
        assign rd_id_o[r]  = id_q[rd_idx_i[r]];
    end

    // Valid flags: reset and clear empty the table, training sets two entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_a_i] <= 1'b1;
            vld_q[wr_idx_b_i] <= 1'b1;
        end
    end

    // ID storage: training writes the same ID to both entries.
    always_ff @(posedge clk) begin
        if (wr_en_i && !clr_i) begin
            id_q[wr_idx_a_i] <= wr_id_i;
            id_q[wr_idx_b_i] <= wr_id_i;
        end
    end

    AST_IDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld_q == '0));                                      // R9
    AST_IDT_TRAIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (vld_q[$past(wr_idx_a_i)] && vld_q[$past(wr_idx_b_i)]
            && id_q[$past(wr_idx_a_i)] == $past(wr_id_i)
            && id_q[$past(wr_idx_b_i)] == $past(wr_id_i)));            // R6
endmodule

// File: rtl/ssp_train.sv
// Module: violation training rule. It chooses the set ID that the store and
// load entries will share.
// Assumes: the inputs are the current table contents; the logic is purely combinational.
module ssp_train
    import ssp_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  logic             st_vld_i,
    input  logic [SET_W-1:0] st_id_i,
    input  logic             ld_vld_i,
    input  logic [SET_W-1:0] ld_id_i,
    input  logic [SET_W-1:0] fresh_id_i,
    output logic [SET_W-1:0] new_id_o
);
    train_case_e sel;

    // Decide the case from the two valid flags.
    always_comb begin
        sel = train_case_e'({ld_vld_i, st_vld_i});
    end

    // Pick the ID for the chosen case.
    always_comb begin
        unique case (sel)
            TR_FRESH:  new_id_o = fresh_id_i;
            TR_USE_ST: new_id_o = st_id_i;
            TR_USE_LD: new_id_o = ld_id_i;
            default:   new_id_o = (st_id_i < ld_id_i) ? st_id_i : ld_id_i;
        endcase
    end

    // The merged ID is never larger than either input ID.
    always_comb begin
        if (st_vld_i && ld_vld_i) begin
            AST_TRAIN_MIN: assert (new_id_o <= st_id_i && new_id_o <= ld_id_i); // R6
        end
    end
endmodule

// File: rtl/ssp_lfst.sv
// Module: last-store table. Each set holds the valid flag, sequence number and
// thread tag of the newest in-flight store of that set.
// Assumes: within an entry, updates apply in the order issue-drop, insert,
// squash, clear, so a later update overrides an earlier one.
module ssp_lfst #(
    parameter int SET_W = 4,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ins_en_i,
    input  logic [SET_W-1:0] ins_set_i,
    input  logic [SEQ_W-1:0] ins_seq_i,
    input  logic [TID_W-1:0] ins_tid_i,
    input  logic             iss_en_i,
    input  logic [SET_W-1:0] iss_set_i,
    input  logic [SEQ_W-1:0] iss_seq_i,
    input  logic             sq_en_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    input  logic [TID_W-1:0] sq_tid_i,
    input  logic [SET_W-1:0] rd_set_i,
    output logic             rd_vld_o,
    output logic [SEQ_W-1:0] rd_seq_o
);
    localparam int NSET = 1 << SET_W;

    logic [NSET-1:0]  vld_w;
    logic [SEQ_W-1:0] seq_w [NSET];

    for (genvar i = 0; i < NSET; i++) begin : g_set
        logic             v_q, v_n;
        logic [SEQ_W-1:0] s_q, s_n;
        logic [TID_W-1:0] t_q, t_n;
        logic             ins_hit, iss_hit;

        assign ins_hit = ins_en_i && (ins_set_i == SET_W'(i));
        assign iss_hit = iss_en_i && (iss_set_i == SET_W'(i)) && v_q && (s_q == iss_seq_i);

        // Next state of this set from all update sources.
        always_comb begin
            v_n = v_q;
            s_n = s_q;
            t_n = t_q;
            if (iss_hit) v_n = 1'b0;
            if (ins_hit) begin
                v_n = 1'b1;
                s_n = ins_seq_i;
                t_n = ins_tid_i;
            end
            if (sq_en_i && v_n && (s_n > sq_seq_i) && (t_n == sq_tid_i)) v_n = 1'b0;
            if (clr_i) v_n = 1'b0;
        end

        // Register the entry; reset invalidates it.
        always_ff @(posedge clk) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= v_n;
            s_q <= s_n;
            t_q <= t_n;
        end

        assign vld_w[i] = v_q;
        assign seq_w[i] = s_q;

        AST_LFST_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_hit && !clr_i && !(sq_en_i && ins_seq_i > sq_seq_i && ins_tid_i == sq_tid_i))
            |=> (v_q && s_q == $past(ins_seq_i)));                     // R4
        AST_LFST_ISSUE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_hit && !ins_hit) |=> !v_q);                           // R7
        AST_LFST_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_en_i && v_q && s_q > sq_seq_i && t_q == sq_tid_i && !ins_hit) |=> !v_q); // R8
        AST_LFST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !v_q);                                           // R11
    end

    // Combinational read of one set.
    assign rd_vld_o = vld_w[rd_set_i];
    assign rd_seq_o = seq_w[rd_set_i];
endmodule

// File: rtl/ssp_predictor.sv
// Module: store set memory dependence predictor (top). It derives table indices
// and fresh set IDs from addresses and connects the set-ID table, the training
// rule and the last-store table.
// Assumes: sequence number 0 is never used by the pipeline; it means "no dependence".
module ssp_predictor #(
    parameter int PC_W        = 32,
    parameter int OFFSET_BITS = 2,
    parameter int IDX_W       = 6,
    parameter int SET_W       = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             disp_vld_i,
    input  logic             disp_store_i,
    input  logic [PC_W-1:0]  disp_pc_i,
    input  logic [SEQ_W-1:0] disp_seq_i,
    input  logic [TID_W-1:0] disp_tid_i,
    input  logic [PC_W-1:0]  look_pc_i,
    output logic             look_dep_o,
    output logic [SEQ_W-1:0] look_seq_o,
    input  logic             issue_vld_i,
    input  logic             issue_store_i,
    input  logic [PC_W-1:0]  issue_pc_i,
    input  logic [SEQ_W-1:0] issue_seq_i,
    input  logic             viol_vld_i,
    input  logic [PC_W-1:0]  viol_store_pc_i,
    input  logic [PC_W-1:0]  viol_load_pc_i,
    input  logic             sqsh_vld_i,
    input  logic [SEQ_W-1:0] sqsh_seq_i,
    input  logic [TID_W-1:0] sqsh_tid_i
);
    localparam int NRD     = 5;
    localparam int RP_LOOK = 0;
    localparam int RP_DISP = 1;
    localparam int RP_ISS  = 2;
    localparam int RP_VST  = 3;
    localparam int RP_VLD  = 4;
    localparam int HASH_SH = 10;

    // Table index of an address (R1).
    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return pc[OFFSET_BITS +: IDX_W];
    endfunction

    // Fresh set ID of an address (R2).
    function automatic logic [SET_W-1:0] hash_of(input logic [PC_W-1:0] pc);
        logic [PC_W-1:0] mix;
        mix = pc ^ (pc >> HASH_SH);
        return mix[SET_W-1:0];
    endfunction

    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0]            rd_vld;
    logic [NRD-1:0][SET_W-1:0] rd_id;
    logic [SET_W-1:0]          train_id;
    logic                      lf_vld;
    logic [SEQ_W-1:0]          lf_seq;
    logic                      ins_en, iss_en;

    // Address indices for all read ports.
    always_comb begin
        rd_idx[RP_LOOK] = idx_of(look_pc_i);
        rd_idx[RP_DISP] = idx_of(disp_pc_i);
        rd_idx[RP_ISS]  = idx_of(issue_pc_i);
        rd_idx[RP_VST]  = idx_of(viol_store_pc_i);
        rd_idx[RP_VLD]  = idx_of(viol_load_pc_i);
    end

    ssp_idt #(.IDX_W(IDX_W), .SET_W(SET_W), .NRD(NRD)) i_idt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .rd_idx_i   (rd_idx),
        .rd_vld_o   (rd_vld),
        .rd_id_o    (rd_id),
        .wr_en_i    (viol_vld_i),
        .wr_idx_a_i (rd_idx[RP_VST]),
        .wr_idx_b_i (rd_idx[RP_VLD]),
        .wr_id_i    (train_id)
    );

    ssp_train #(.SET_W(SET_W)) i_train (
        .st_vld_i   (rd_vld[RP_VST]),
        .st_id_i    (rd_id[RP_VST]),
        .ld_vld_i   (rd_vld[RP_VLD]),
        .ld_id_i    (rd_id[RP_VLD]),
        .fresh_id_i (hash_of(viol_store_pc_i)),
        .new_id_o   (train_id)
    );

    // Only stores that have a valid set ID touch the last-store table.
    assign ins_en = disp_vld_i && disp_store_i && rd_vld[RP_DISP];
    assign iss_en = issue_vld_i && issue_store_i && rd_vld[RP_ISS];

    ssp_lfst #(.SET_W(SET_W), .SEQ_W(SEQ_W), .TID_W(TID_W)) i_lfst (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .ins_en_i  (ins_en),
        .ins_set_i (rd_id[RP_DISP]),
        .ins_seq_i (disp_seq_i),
        .ins_tid_i (disp_tid_i),
        .iss_en_i  (iss_en),
        .iss_set_i (rd_id[RP_ISS]),
        .iss_seq_i (issue_seq_i),
        .sq_en_i   (sqsh_vld_i),
        .sq_seq_i  (sqsh_seq_i),
        .sq_tid_i  (sqsh_tid_i),
        .rd_set_i  (rd_id[RP_LOOK]),
        .rd_vld_o  (lf_vld),
        .rd_seq_o  (lf_seq)
    );

    // Lookup result: both tables must be valid.
    always_comb begin
        look_dep_o = rd_vld[RP_LOOK] && lf_vld;
        look_seq_o = look_dep_o ? lf_seq : '0;
    end

    AST_LOAD_NO_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld_i && !disp_store_i) |-> !ins_en);                    // R5
    AST_CLEAR_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !look_dep_o);                                        // R9
endmodule

// File: tb/test_ssp_predictor.sv
module test_ssp_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;
    localparam int TID_W = 2;

    localparam logic [2:0] OP_NONE = 3'd0, OP_VIO = 3'd1, OP_ST = 3'd2, OP_LD = 3'd3,
                           OP_ISS = 3'd4, OP_SQ = 3'd5, OP_CLR = 3'd6;

    // Addresses, with their index (pc[7:2]) and fresh hash (low 4 bits of pc^(pc>>10)).
    localparam logic [31:0] S1 = 32'h104;  // idx 1,  hash 4
    localparam logic [31:0] L1 = 32'h208;  // idx 2,  hash 8
    localparam logic [31:0] S2 = 32'h30C;  // idx 3,  hash 12
    localparam logic [31:0] L2 = 32'h410;  // idx 4,  hash 1
    localparam logic [31:0] S3 = 32'h51C;  // idx 7,  hash 13
    localparam logic [31:0] S4 = 32'h444;  // idx 17, hash 5 (bit 10 set; without the XOR term it would be 4)

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] pa;
        logic [31:0] pb;
        logic [15:0] seq;
        logic [1:0]  tid;
        logic [31:0] cpc;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, L1, 16'd0,  8'd3},  // R3 nothing learned
        '{OP_VIO,  S1,    L1,     16'd0, 2'd0, L1, 16'd0,  8'd6},  // R6 fresh set 4, empty last-store entry
        '{OP_LD,   L1,    32'h0,  16'd5, 2'd0, L1, 16'd0,  8'd5},  // R5 load writes nothing
        '{OP_ST,   S1,    32'h0,  16'd10,2'd0, L1, 16'd10, 8'd4},  // R4
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, S1, 16'd10, 8'd1},  // R1 store itself shares the set
        '{OP_ST,   S1,    32'h0,  16'd20,2'd1, L1, 16'd20, 8'd4},  // R4 newer store overwrites
        '{OP_ISS,  S1,    32'h0,  16'd10,2'd0, L1, 16'd20, 8'd7},  // R7 stale issue ignored
        '{OP_ISS,  S1,    32'h0,  16'd20,2'd0, L1, 16'd0,  8'd7},  // R7 matching issue drops
        '{OP_ST,   S2,    32'h0,  16'd30,2'd0, S2, 16'd0,  8'd4},  // R4 store without set ID
        '{OP_VIO,  S2,    L2,     16'd0, 2'd0, L2, 16'd0,  8'd6},  // R6 fresh set 12
        '{OP_ST,   S2,    32'h0,  16'd33,2'd0, L2, 16'd33, 8'd2},  // R2 set 12 from store hash
        '{OP_ISS,  S2,    32'h0,  16'd33,2'd0, L2, 16'd0,  8'd7},  // R7
        '{OP_VIO,  S2,    L1,     16'd0, 2'd0, L1, 16'd0,  8'd6},  // R6 merge min(12,4)=4
        '{OP_ST,   S2,    32'h0,  16'd40,2'd0, L1, 16'd40, 8'd6},  // R6 S2 now in set 4
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, L2, 16'd0,  8'd6},  // R6 L2 kept set 12
        '{OP_VIO,  S3,    L2,     16'd0, 2'd0, S3, 16'd0,  8'd6},  // R6 S3 copies 12
        '{OP_ST,   S3,    32'h0,  16'd50,2'd1, L2, 16'd50, 8'd6},  // R6
        '{OP_SQ,   32'h0, 32'h0,  16'd45,2'd1, L2, 16'd0,  8'd8},  // R8 younger same thread
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, L1, 16'd40, 8'd8},  // R8 other thread kept
        '{OP_SQ,   32'h0, 32'h0,  16'd35,2'd0, L1, 16'd0,  8'd8},  // R8
        '{OP_ST,   S1,    32'h0,  16'd60,2'd0, L1, 16'd60, 8'd4},  // R4
        '{OP_SQ,   32'h0, 32'h0,  16'd60,2'd0, L1, 16'd60, 8'd8},  // R8 equal kept
        '{OP_SQ,   32'h0, 32'h0,  16'd10,2'd1, L1, 16'd60, 8'd8},  // R8 wrong thread
        '{OP_CLR,  32'h0, 32'h0,  16'd0, 2'd0, L1, 16'd0,  8'd9},  // R9
        '{OP_ST,   S1,    32'h0,  16'd70,2'd0, L1, 16'd0,  8'd9},  // R9 set IDs gone too
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, S1, 16'd0,  8'd9},  // R9
        '{OP_VIO,  S1,    L2,     16'd0, 2'd0, L2, 16'd0,  8'd6},  // R6 fresh set 4
        '{OP_VIO,  S4,    L1,     16'd0, 2'd0, L1, 16'd0,  8'd2},  // R2 fresh set 5
        '{OP_ST,   S1,    32'h0,  16'd90,2'd0, L1, 16'd0,  8'd2},  // R2 set 4 is not L1's set
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, L2, 16'd90, 8'd2},  // R2
        '{OP_ST,   S4,    32'h0,  16'd95,2'd0, L1, 16'd95, 8'd2},  // R2
        '{OP_NONE, 32'h0, 32'h0,  16'd0, 2'd0, L2, 16'd90, 8'd4}   // R4 sets independent
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clr;
    logic             disp_vld, disp_store;
    logic [PC_W-1:0]  disp_pc;
    logic [SEQ_W-1:0] disp_seq;
    logic [TID_W-1:0] disp_tid;
    logic [PC_W-1:0]  look_pc;
    logic             look_dep;
    logic [SEQ_W-1:0] look_seq;
    logic             iss_vld, iss_store;
    logic [PC_W-1:0]  iss_pc;
    logic [SEQ_W-1:0] iss_seq;
    logic             vio_vld;
    logic [PC_W-1:0]  vio_st, vio_ld;
    logic             sq_vld;
    logic [SEQ_W-1:0] sq_seq;
    logic [TID_W-1:0] sq_tid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_predictor i_ssp_predictor (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .disp_vld_i(disp_vld), .disp_store_i(disp_store), .disp_pc_i(disp_pc),
        .disp_seq_i(disp_seq), .disp_tid_i(disp_tid),
        .look_pc_i(look_pc), .look_dep_o(look_dep), .look_seq_o(look_seq),
        .issue_vld_i(iss_vld), .issue_store_i(iss_store), .issue_pc_i(iss_pc),
        .issue_seq_i(iss_seq),
        .viol_vld_i(vio_vld), .viol_store_pc_i(vio_st), .viol_load_pc_i(vio_ld),
        .sqsh_vld_i(sq_vld), .sqsh_seq_i(sq_seq), .sqsh_tid_i(sq_tid)
    );

    task automatic idle();
        clr = 1'b0; disp_vld = 1'b0; disp_store = 1'b0; disp_pc = '0; disp_seq = '0; disp_tid = '0;
        iss_vld = 1'b0; iss_store = 1'b0; iss_pc = '0; iss_seq = '0;
        vio_vld = 1'b0; vio_st = '0; vio_ld = '0; sq_vld = 1'b0; sq_seq = '0; sq_tid = '0;
    endtask

    // Lookup is combinational: set the address, settle, compare both outputs.
    task automatic check_look(input logic [31:0] pc, input logic [15:0] exp, input string tag);
        look_pc = pc;
        #1;
        checks++;
        if (look_seq !== exp || look_dep !== (exp != 16'd0)) begin
            failures++;
            $display("FAIL %s pc=%h actual seq=%0d dep=%0b expected seq=%0d dep=%0b",
                     tag, pc, look_seq, look_dep, exp, (exp != 16'd0));
        end
    endtask

    // Drive one vector's operation for one clock, then return to idle at the negedge.
    task automatic apply(input vec_t v);
        idle();
        case (v.op)
            OP_VIO: begin vio_vld = 1'b1; vio_st = v.pa; vio_ld = v.pb; end
            OP_ST:  begin disp_vld = 1'b1; disp_store = 1'b1; disp_pc = v.pa; disp_seq = v.seq; disp_tid = v.tid; end
            OP_LD:  begin disp_vld = 1'b1; disp_pc = v.pa; disp_seq = v.seq; disp_tid = v.tid; end
            OP_ISS: begin iss_vld = 1'b1; iss_store = 1'b1; iss_pc = v.pa; iss_seq = v.seq; end
            OP_SQ:  begin sq_vld = 1'b1; sq_seq = v.seq; sq_tid = v.tid; end
            OP_CLR: clr = 1'b1;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        look_pc = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset leaves every table entry invalid
        check_look(S1, 16'd0, "R10 reset S1");
        check_look(L1, 16'd0, "R10 reset L1");

        // Vector table
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            check_look(VECS[k].cpc, VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
        end

        // R11: a squash in the same cycle cancels the new insert (set 4 held 90 from tid 0)
        idle();
        disp_vld = 1'b1; disp_store = 1'b1; disp_pc = S1; disp_seq = 16'd100; disp_tid = 2'd0;
        sq_vld = 1'b1; sq_seq = 16'd99; sq_tid = 2'd0;
        @(posedge clk); @(negedge clk); idle();
        check_look(L2, 16'd0, "R11 squash cancels same-cycle insert");
        check_look(L1, 16'd95, "R11 squash spares older entry");

        // R11: clear wins over a same-cycle store insert
        disp_vld = 1'b1; disp_store = 1'b1; disp_pc = S4; disp_seq = 16'd110;
        clr = 1'b1;
        @(posedge clk); @(negedge clk); idle();
        check_look(L1, 16'd0, "R11 clear beats insert");

        // R9: clear wins over a same-cycle violation, so nothing is trained
        vio_vld = 1'b1; vio_st = S1; vio_ld = L1; clr = 1'b1;
        @(posedge clk); @(negedge clk); idle();
        disp_vld = 1'b1; disp_store = 1'b1; disp_pc = S1; disp_seq = 16'd120;
        @(posedge clk); @(negedge clk); idle();
        check_look(L1, 16'd0, "R9 clear beats training");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule